// File: doc/BRIEF.md
# Region-Based Address Translator

This block remaps 32-bit request addresses into a 48-bit address space. Software programs up to four translation regions through a small register port. Each region has an enable, a power-of-two size code, a source base and a 48-bit translated base. The translated base is split into a 32-bit low word and a 16-bit high word.

Each incoming address is compared against every enabled region in the same cycle, without a clock edge. When an address hits, its low N bits (N being the region's size code) pass through unchanged. The bits above them are replaced by the translated base. When nothing hits, the address goes out zero-extended and a miss flag is raised. A read-only configuration word lets software discover the block's geometry.

Top module: `xlt_region_translator`

## Requirements
- R1: After reset every region is disabled, and its size, source base and both translated words read as zero. A valid lookup then misses.
- R2: The word at register offset 04h is read-only and reads 0x00300304: output address width 48 in bits 23:16, address count 3 in bits 15:8, region count 4 in bits 7:0.
- R3: Region j (0 to 3) is programmed at four register offsets: control at 20h+10h*j, source base at 24h+10h*j, translated low word at 28h+10h*j, translated high word at 2Ch+10h*j. Control bit 31 is the enable and control bits 5:0 are the size code. The high word uses bits 15:0. All of these read back as written.
- R4: Control bits 30:6 and high-word bits 31:16 read as zero, whatever was written to them. Offsets that are not mapped read as zero and ignore writes.
- R5: A valid address hits region j when the region is enabled and address bits 31:N equal bits 31:N of the source base.
- R6: On a hit, output bits N-1:0 equal the input address bits, and output bits 47:N equal the same bits of {high word[15:0], low word}. The winning region's index is reported.
- R7: When no region hits a valid address, the output is the input address zero-extended to 48 bits, the miss flag is 1 and the hit flag is 0.
- R8: When several enabled regions match, the lowest-numbered one wins.
- R9: A size code above 32 behaves as 32. With size 32 every address hits, and the output's upper 16 bits come from the high word.
- R10: Size code 0 matches exactly one byte address, and the whole 48-bit output comes from the translated base.
- R11: A disabled region never hits, whatever its other settings.
- R12: When the valid input is low, both the hit and the miss flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| in_valid_i | input | 1 | Lookup request valid |
| in_addr_i | input | 32 | Address to translate |
| out_hit_o | output | 1 | A region matched |
| out_miss_o | output | 1 | Valid request matched no region |
| out_region_o | output | 2 | Index of the winning region (0 on miss) |
| out_addr_o | output | 48 | Translated address |

## Verification
The assertions assume that register offsets are word-aligned, since bits 1:0 of the offset are not decoded. The write-readback property assumes that nothing else writes between a write and the read that follows it. The bench keeps to both: it only uses aligned offsets, and it finishes each write before it reads. It programs source bases and translated low words aligned to their region size. Unaligned bases are left outside what the expected values claim.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  localparam int IN_AW   = 32;
  localparam int OUT_AW  = 48;
  localparam int HI_W    = OUT_AW - IN_AW;
  localparam int SIZE_W  = 6;

  typedef struct packed {
    logic              en;
    logic [SIZE_W-1:0] size;
    logic [IN_AW-1:0]  base;
    logic [IN_AW-1:0]  lo;
    logic [HI_W-1:0]   hi;
  } region_cfg_t;
endpackage

// File: rtl/xlt_regfile.sv
module xlt_regfile
  import xlt_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int REG_AW      = 12,
  parameter int ADDR_CNT    = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [REG_AW-1:0]             addr_i,
  input  logic [31:0]                   wdata_i,
  output logic [31:0]                   rdata_o,
  output region_cfg_t [NUM_REGIONS-1:0] cfg_o
);
  localparam int IDX_W     = REG_AW - 4;
  localparam int FIRST_BLK = 2;
  localparam logic [31:0] CFG_WORD = {8'h00, 8'(OUT_AW), 8'(ADDR_CNT), 8'(NUM_REGIONS)};

  region_cfg_t [NUM_REGIONS-1:0] cfg_q;
  logic [IDX_W-1:0] blk;
  logic [1:0]       word;
  logic [1:0]       unused_low;

  assign blk        = addr_i[REG_AW-1:4];
  assign word       = addr_i[3:2];
  assign unused_low = addr_i[1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (we_i) begin
      for (int j = 0; j < NUM_REGIONS; j++) begin
        if (blk == IDX_W'(j + FIRST_BLK)) begin
          case (word)
            2'd0: begin
              cfg_q[j].en   <= wdata_i[31];
              cfg_q[j].size <= wdata_i[SIZE_W-1:0];
            end
            2'd1: cfg_q[j].base <= wdata_i;
            2'd2: cfg_q[j].lo   <= wdata_i;
            default: cfg_q[j].hi <= wdata_i[HI_W-1:0];
          endcase
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (blk == '0 && word == 2'd1) rdata_o = CFG_WORD;
    for (int j = 0; j < NUM_REGIONS; j++) begin
      if (blk == IDX_W'(j + FIRST_BLK)) begin
        case (word)
          2'd0: rdata_o = {cfg_q[j].en, {(31-SIZE_W){1'b0}}, cfg_q[j].size};
          2'd1: rdata_o = cfg_q[j].base;
          2'd2: rdata_o = cfg_q[j].lo;
          default: rdata_o = {{(32-HI_W){1'b0}}, cfg_q[j].hi};
        endcase
      end
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/xlt_region_match.sv
module xlt_region_match
  import xlt_pkg::*;
(
  input  region_cfg_t       cfg_i,
  input  logic [IN_AW-1:0]  addr_i,
  output logic              hit_o,
  output logic [OUT_AW-1:0] xlat_o
);
  logic [SIZE_W-1:0] n_eff;
  logic [OUT_AW-1:0] keep_mask;
  logic [IN_AW-1:0]  cmp_mask;

  // codes above the address width clamp to a full-space region
  assign n_eff     = (cfg_i.size > SIZE_W'(IN_AW)) ? SIZE_W'(IN_AW) : cfg_i.size;
  assign keep_mask = (OUT_AW'(1) << n_eff) - OUT_AW'(1);
  assign cmp_mask  = ~keep_mask[IN_AW-1:0];
  assign hit_o     = cfg_i.en && (((addr_i ^ cfg_i.base) & cmp_mask) == '0);
  assign xlat_o    = ({cfg_i.hi, cfg_i.lo} & ~keep_mask) |
                     ({{HI_W{1'b0}}, addr_i} & keep_mask);
endmodule

// File: rtl/xlt_prio_sel.sv
module xlt_prio_sel
  import xlt_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic [NUM_REGIONS-1:0]             hit_i,
  input  logic [NUM_REGIONS-1:0][OUT_AW-1:0] xlat_i,
  output logic                               any_o,
  output logic [IDX_W-1:0]                   idx_o,
  output logic [OUT_AW-1:0]                  xlat_o
);
  always_comb begin
    any_o  = 1'b0;
    idx_o  = '0;
    xlat_o = '0;
    // descend so the lowest index is applied last and wins
    for (int j = NUM_REGIONS - 1; j >= 0; j--) begin
      if (hit_i[j]) begin
        any_o  = 1'b1;
        idx_o  = IDX_W'(j);
        xlat_o = xlat_i[j];
      end
    end
  end
endmodule

// File: rtl/xlt_region_translator.sv
module xlt_region_translator
  import xlt_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int REG_AW      = 12,
  parameter int ADDR_CNT    = 3,
  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              in_valid_i,
  input  logic [IN_AW-1:0]  in_addr_i,
  output logic              out_hit_o,
  output logic              out_miss_o,
  output logic [IDX_W-1:0]  out_region_o,
  output logic [OUT_AW-1:0] out_addr_o
);
  region_cfg_t [NUM_REGIONS-1:0]      cfg;
  logic [NUM_REGIONS-1:0]             hits;
  logic [NUM_REGIONS-1:0][OUT_AW-1:0] xlats;
  logic                               any_hit;
  logic [IDX_W-1:0]                   sel_idx;
  logic [OUT_AW-1:0]                  sel_xlat;

  xlt_regfile #(
    .NUM_REGIONS(NUM_REGIONS), .REG_AW(REG_AW), .ADDR_CNT(ADDR_CNT)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .cfg_o(cfg)
  );

  for (genvar j = 0; j < NUM_REGIONS; j++) begin : g_region
    xlt_region_match u_match (
      .cfg_i(cfg[j]), .addr_i(in_addr_i), .hit_o(hits[j]), .xlat_o(xlats[j])
    );
  end

  xlt_prio_sel #(.NUM_REGIONS(NUM_REGIONS)) u_sel (
    .hit_i(hits), .xlat_i(xlats), .any_o(any_hit), .idx_o(sel_idx), .xlat_o(sel_xlat)
  );

  assign out_hit_o    = in_valid_i && any_hit;
  assign out_miss_o   = in_valid_i && !any_hit;
  assign out_region_o = out_hit_o ? sel_idx : '0;
  assign out_addr_o   = out_hit_o ? sel_xlat : {{HI_W{1'b0}}, in_addr_i};
endmodule

// File: rtl/xlt_checker.sv
module xlt_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_we_i,
  input logic [11:0] reg_addr_i,
  input logic [31:0] reg_wdata_i,
  input logic [31:0] reg_rdata_o,
  input logic        in_valid_i,
  input logic [31:0] in_addr_i,
  input logic        out_hit_o,
  input logic        out_miss_o,
  input logic [1:0]  out_region_o,
  input logic [47:0] out_addr_o
);
  AST_CFG_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_addr_i == 12'h004 |-> reg_rdata_o == 32'h0030_0304); // R2

  AST_BASE_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 12'h024) |=>
      (reg_we_i || reg_addr_i != 12'h024 || reg_rdata_o == $past(reg_wdata_i))); // R3

  AST_CTRL_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i[3:0] == 4'h0 && reg_addr_i[11:4] >= 8'd2 && reg_addr_i[11:4] <= 8'd5)
      |-> reg_rdata_o[30:6] == '0); // R4

  AST_MISS_ZEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_miss_o |-> (out_addr_o == {16'h0, in_addr_i} && out_region_o == 2'd0)); // R7

  AST_HIT_MISS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(out_hit_o && out_miss_o)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |-> (!out_hit_o && !out_miss_o)); // R12

  AST_VALID_RESOLVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |-> (out_hit_o || out_miss_o)); // R5
endmodule

bind xlt_region_translator xlt_checker u_chk (.*);

// File: tb/tb_xlt_region_translator.sv
module tb_xlt_region_translator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        in_valid = 1'b0;
  logic [31:0] in_addr = '0;
  logic        out_hit, out_miss;
  logic [1:0]  out_region;
  logic [47:0] out_addr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  xlt_region_translator dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .in_valid_i(in_valid),
    .in_addr_i(in_addr), .out_hit_o(out_hit), .out_miss_o(out_miss),
    .out_region_o(out_region), .out_addr_o(out_addr)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_check(string tag, logic [11:0] a, logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1 check(tag, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic look(string tag, logic [31:0] a, logic exp_hit, logic [1:0] exp_reg,
                      logic [47:0] exp_out);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a;
    #1;
    check({tag, " hit"}, 64'(out_hit), 64'(exp_hit));
    check({tag, " miss"}, 64'(out_miss), 64'(!exp_hit));
    check({tag, " region"}, 64'(out_region), 64'(exp_reg));
    check({tag, " addr"}, 64'(out_addr), 64'(exp_out));
  endtask

  task automatic t_reset;
    for (int j = 0; j < 4; j++) begin
      for (int w = 0; w < 4; w++) rd_check("R1 reset reg", 12'(32 + 16*j + 4*w), 32'h0);
    end
    look("R1 reset lookup", 32'h0000_1234, 1'b0, 2'd0, 48'h0000_0000_1234);
  endtask

  task automatic t_config;
    rd_check("R2 config word", 12'h004, 32'h0030_0304);
    wr(12'h004, 32'hFFFF_FFFF);
    rd_check("R2 config after write", 12'h004, 32'h0030_0304);
  endtask

  task automatic t_regmap;
    wr(12'h030, 32'hFFFF_FFFF);
    rd_check("R3 R4 ctrl1 fields", 12'h030, 32'h8000_003F);
    wr(12'h030, 32'h0);
    rd_check("R3 ctrl1 cleared", 12'h030, 32'h0);
    wr(12'h04C, 32'hABCD_1234);
    rd_check("R4 hi2 reserved", 12'h04C, 32'h0000_1234);
    wr(12'h04C, 32'h0);
    wr(12'h054, 32'hDEAD_BEEF);
    rd_check("R3 base3", 12'h054, 32'hDEAD_BEEF);
    wr(12'h054, 32'h0);
    wr(12'h010, 32'h1234_5678);
    rd_check("R4 unmapped 10h", 12'h010, 32'h0);
    rd_check("R4 unmapped 800h", 12'h800, 32'h0);
  endtask

  task automatic t_basic;
    wr(12'h024, 32'h4000_0000);
    wr(12'h028, 32'h8000_0000);
    wr(12'h02C, 32'h0000_0012);
    wr(12'h020, 32'h8000_0010);
    rd_check("R3 ctrl0", 12'h020, 32'h8000_0010);
    look("R5 R6 region0 hit", 32'h4000_ABCD, 1'b1, 2'd0, 48'h0012_8000_ABCD);
    look("R5 R7 above region0", 32'h4001_0000, 1'b0, 2'd0, 48'h0000_4001_0000);
  endtask

  task automatic t_priority;
    wr(12'h044, 32'h4000_0000);
    wr(12'h048, 32'h1000_0000);
    wr(12'h04C, 32'h0000_0007);
    wr(12'h040, 32'h8000_0014);
    look("R8 overlap lowest wins", 32'h4000_0010, 1'b1, 2'd0, 48'h0012_8000_0010);
    look("R6 region2 only", 32'h400F_0000, 1'b1, 2'd2, 48'h0007_100F_0000);
  endtask

  task automatic t_disable;
    wr(12'h020, 32'h0000_0010);
    look("R11 region0 disabled", 32'h4000_0010, 1'b1, 2'd2, 48'h0007_1000_0010);
  endtask

  task automatic t_big;
    wr(12'h05C, 32'h0000_00FF);
    wr(12'h050, 32'h8000_0028);
    look("R9 size above 32", 32'h9999_0000, 1'b1, 2'd3, 48'h00FF_9999_0000);
    look("R8 R9 region2 beats 3", 32'h4000_0004, 1'b1, 2'd2, 48'h0007_1000_0004);
  endtask

  task automatic t_byte;
    wr(12'h034, 32'h0000_1003);
    wr(12'h038, 32'h0000_2222);
    wr(12'h03C, 32'h0000_0001);
    wr(12'h030, 32'h8000_0000);
    look("R10 exact byte", 32'h0000_1003, 1'b1, 2'd1, 48'h0001_0000_2222);
    look("R10 neighbour byte", 32'h0000_1002, 1'b1, 2'd3, 48'h00FF_0000_1002);
  endtask

  task automatic t_idle;
    @(negedge clk);
    in_valid = 1'b0; in_addr = 32'h0000_1003;
    #1;
    check("R12 idle hit", 64'(out_hit), 64'd0);
    check("R12 idle miss", 64'(out_miss), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_config;
    t_regmap;
    t_basic;
    t_priority;
    t_disable;
    t_big;
    t_byte;
    t_idle;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule